// File: doc/BRIEF.md
# Registered Carry-Select Adder/Subtractor

This block adds or subtracts two operands of a parameterised width and captures the result in an output register. The datapath is built from 10-bit slices. Every bit position works out its sum and carry twice at the same time: once as if its group received a carry of 0, and once as if it received a carry of 1. Each slice is split into two 5-bit groups. At each group boundary, the real incoming carry picks one of the two precomputed results, so the long path only passes through one multiplexer per group. Slices pass their carry-out to the next slice's carry-in.

A run-time control chooses between addition and subtraction. In subtract mode, operand B is inverted and the control value is fed in as the carry of the first arithmetic bit. A parameter can move the first arithmetic bit above bit 0 inside the lowest slice. Bits below that point pass operand A through unchanged.

The output register of each bit has two asynchronous controls, a clear and a load, plus a clock enable. Under the clock enable it also has a synchronous clear and a synchronous load. The carry out of the top bit is available both directly and through a register.

Top module: `csAddSub`

## Requirements
- R1: With `subMode`=0 and `clkEn`=1, and neither synchronous control asserted, a rising edge of `clk` loads `sumQ` with (opA + opB) mod 2^WIDTH and loads `carryQ` with the carry out of the top bit.
- R2: With `subMode`=1, the same edge loads `sumQ` with (opA − opB) mod 2^WIDTH and loads `carryQ` with 1 exactly when opA ≥ opB, read as unsigned numbers. This carry is the one produced by opA + ~opB + 1.
- R3: A carry that enters at bit 0 is correct when it ripples across the 5-bit group boundaries (bit 4→5 and bit 14→15) and across the slice boundary (bit 9→10).
- R4: `carryComb` gives the top carry of the current operands in the same cycle, without waiting for a clock edge.
- R5: While `clkEn`=0, neither `sumQ` nor `carryQ` changes at a clock edge, whatever the operands are.
- R6: While `aClr`=1, `sumQ` and `carryQ` are 0 at once, without a clock edge. `aClr` takes priority over every other control.
- R7: While `aLoad`=1 and `aClr`=0, `sumQ` equals `aLoadData` and `carryQ` is 0 at once, without a clock edge.
- R8: With `clkEn`=1 and `sClr`=1, a clock edge clears `sumQ` and `carryQ`. In that cycle `sClr` overrides `sLoad`.
- R9: With `clkEn`=1, `sLoad`=1 and `sClr`=0, a clock edge loads `sumQ` with `sLoadData` and sets `carryQ` to 0.
- R10: `sClr` and `sLoad` have no effect while `clkEn`=0.
- R11: With CHAIN_START=S>0, bits S−1..0 of the result equal opA[S−1:0]. The upper bits hold opA[W−1:S] ± opB[W−1:S], with the add/subtract control fed in as the carry into bit S. The top carry comes from that upper operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| aClr | input | 1 | Asynchronous clear of the output register, active high |
| aLoad | input | 1 | Asynchronous load of the output register, active high |
| aLoadData | input | WIDTH | Value loaded by `aLoad` |
| clkEn | input | 1 | Clock enable for every synchronous update |
| sClr | input | 1 | Synchronous clear, used only when `clkEn` is high |
| sLoad | input | 1 | Synchronous load, used only when `clkEn` is high |
| sLoadData | input | WIDTH | Value loaded by `sLoad` |
| subMode | input | 1 | 0 = add, 1 = subtract |
| opA | input | WIDTH | Operand A |
| opB | input | WIDTH | Operand B |
| sumComb | output | WIDTH | Result before the register |
| carryComb | output | 1 | Top carry before the register |
| sumQ | output | WIDTH | Registered result |
| carryQ | output | 1 | Registered top carry |

## Verification
Several controls can be asserted in the same cycle, and the tests target those overlaps. In one enabled cycle, the synchronous clear and the synchronous load are both raised together with live operands; the test passes only if the register comes out all zeros. The synchronous clear and load are also raised while the enable is low; the test passes only if the registered sum and carry keep their earlier values. For the asynchronous controls, load and clear are raised together between clock edges; the outputs are read before the next edge and must show the clear winning.

// File: rtl/csAddPkg.sv
package csAddPkg;
  localparam int SLICE_BITS = 10;
  localparam int GROUP_BITS = 5;

  // One strobe per synchronous register action, at most one active per cycle
  typedef struct packed {
    logic doClr;
    logic doLoad;
    logic doSum;
  } regStrobe_t;
endpackage

// File: rtl/csSlice.sv
module csSlice
  import csAddPkg::*;
#(
  parameter int START = 0
) (
  input  logic [SLICE_BITS-1:0] a,
  input  logic [SLICE_BITS-1:0] b,
  input  logic                  cin,
  output logic [SLICE_BITS-1:0] sum,
  output logic                  cout
);
  localparam int NGROUPS = SLICE_BITS / GROUP_BITS;

  logic [SLICE_BITS-1:0] s0, s1;
  logic [SLICE_BITS-1:0] c0In, c1In, c0Out, c1Out;
  logic [NGROUPS:0]      gCarry;

  // Two speculative chains per bit; each group restarts them at 0 and 1
  for (genvar i = 0; i < SLICE_BITS; i++) begin : g_bit
    if (i % GROUP_BITS == 0) begin : g_head
      assign c0In[i] = 1'b0;
      assign c1In[i] = 1'b1;
    end else begin : g_body
      assign c0In[i] = c0Out[i-1];
      assign c1In[i] = c1Out[i-1];
    end

    if (i < START) begin : g_pass
      // Below the chain start: operand A passes, carry propagates unchanged
      assign s0[i]    = a[i];
      assign s1[i]    = a[i];
      assign c0Out[i] = c0In[i];
      assign c1Out[i] = c1In[i];
    end else begin : g_arith
      assign s0[i]    = a[i] ^ b[i] ^ c0In[i];
      assign s1[i]    = a[i] ^ b[i] ^ c1In[i];
      assign c0Out[i] = (a[i] & b[i]) | (c0In[i] & (a[i] ^ b[i]));
      assign c1Out[i] = (a[i] & b[i]) | (c1In[i] & (a[i] ^ b[i]));
    end
  end

  // Real carry selects the precomputed chain at each group boundary
  assign gCarry[0] = cin;
  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    localparam int TOP = g * GROUP_BITS + GROUP_BITS - 1;
    assign sum[g*GROUP_BITS +: GROUP_BITS] =
      gCarry[g] ? s1[g*GROUP_BITS +: GROUP_BITS] : s0[g*GROUP_BITS +: GROUP_BITS];
    assign gCarry[g+1] = gCarry[g] ? c1Out[TOP] : c0Out[TOP];
  end

  assign cout = gCarry[NGROUPS];
endmodule

// File: rtl/csRegCtl.sv
module csRegCtl
  import csAddPkg::*;
(
  input  logic       clkEn,
  input  logic       sClr,
  input  logic       sLoad,
  output regStrobe_t strobe
);
  // Enabled priority: clear, then load, then new sum
  always_comb begin
    strobe        = '0;
    if (clkEn) begin
      if (sClr)       strobe.doClr  = 1'b1;
      else if (sLoad) strobe.doLoad = 1'b1;
      else            strobe.doSum  = 1'b1;
    end
  end
endmodule

// File: rtl/csDatapath.sv
module csDatapath
  import csAddPkg::*;
#(
  parameter int WIDTH = 20,
  parameter int START = 0
) (
  input  logic             clk,
  input  logic             aClr,
  input  logic             aLoad,
  input  logic [WIDTH-1:0] aLoadData,
  input  regStrobe_t       strobe,
  input  logic [WIDTH-1:0] sLoadData,
  input  logic             subMode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sumComb,
  output logic             carryComb,
  output logic [WIDTH-1:0] sumQ,
  output logic             carryQ
);
  localparam int NSLICES = WIDTH / SLICE_BITS;
  localparam int AW      = WIDTH - START;

  logic [WIDTH-1:0] bEff;
  logic [NSLICES:0] sliceCarry;

  assign bEff          = opB ^ {WIDTH{subMode}};
  assign sliceCarry[0] = subMode;

  for (genvar s = 0; s < NSLICES; s++) begin : g_slice
    csSlice #(.START(s == 0 ? START : 0)) u_slice (
      .a   (opA[s*SLICE_BITS +: SLICE_BITS]),
      .b   (bEff[s*SLICE_BITS +: SLICE_BITS]),
      .cin (sliceCarry[s]),
      .sum (sumComb[s*SLICE_BITS +: SLICE_BITS]),
      .cout(sliceCarry[s+1])
    );
  end
  assign carryComb = sliceCarry[NSLICES];

  always_ff @(posedge clk or posedge aClr or posedge aLoad) begin
    if (aClr) begin
      sumQ   <= '0;
      carryQ <= 1'b0;
    end else if (aLoad) begin
      sumQ   <= aLoadData;
      carryQ <= 1'b0;
    end else if (strobe.doClr) begin
      sumQ   <= '0;
      carryQ <= 1'b0;
    end else if (strobe.doLoad) begin
      sumQ   <= sLoadData;
      carryQ <= 1'b0;
    end else if (strobe.doSum) begin
      sumQ   <= sumComb;
      carryQ <= carryComb;
    end
  end

  // Plain ripple reference of the arithmetic bits
  logic [AW:0] refHi;
  assign refHi = {1'b0, opA[WIDTH-1:START]} + {1'b0, bEff[WIDTH-1:START]} + {{AW{1'b0}}, subMode};

  AST_ARITH_MATCH: assert property (@(posedge clk) disable iff (aClr)
    {carryComb, sumComb[WIDTH-1:START]} == refHi); // R1
  AST_SCLR_ZERO: assert property (@(posedge clk) disable iff (aClr || aLoad)
    strobe.doClr |=> (sumQ == '0 && !carryQ)); // R8
  AST_SLOAD_DATA: assert property (@(posedge clk) disable iff (aClr || aLoad)
    strobe.doLoad |=> (sumQ == $past(sLoadData) && !carryQ)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (aClr || aLoad)
    (strobe == '0) |=> ($stable(sumQ) && $stable(carryQ))); // R5
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (aClr)
    $onehot0(strobe)); // R8
endmodule

// File: rtl/csAddSub.sv
module csAddSub
  import csAddPkg::*;
#(
  parameter int WIDTH       = 20,
  parameter int CHAIN_START = 0
) (
  input  logic             clk,
  input  logic             aClr,
  input  logic             aLoad,
  input  logic [WIDTH-1:0] aLoadData,
  input  logic             clkEn,
  input  logic             sClr,
  input  logic             sLoad,
  input  logic [WIDTH-1:0] sLoadData,
  input  logic             subMode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sumComb,
  output logic             carryComb,
  output logic [WIDTH-1:0] sumQ,
  output logic             carryQ
);
  regStrobe_t strobe;

  csRegCtl u_ctl (
    .clkEn (clkEn),
    .sClr  (sClr),
    .sLoad (sLoad),
    .strobe(strobe)
  );

  csDatapath #(.WIDTH(WIDTH), .START(CHAIN_START)) u_dp (
    .clk      (clk),
    .aClr     (aClr),
    .aLoad    (aLoad),
    .aLoadData(aLoadData),
    .strobe   (strobe),
    .sLoadData(sLoadData),
    .subMode  (subMode),
    .opA      (opA),
    .opB      (opB),
    .sumComb  (sumComb),
    .carryComb(carryComb),
    .sumQ     (sumQ),
    .carryQ   (carryQ)
  );
endmodule

// File: tb/csAddSub_tb.sv
module csAddSub_tb;
  localparam int W   = 20;
  localparam int OFS = 3;

  logic clk = 1'b0;
  logic aClr = 1'b1, aLoad = 1'b0, clkEn = 1'b0, sClr = 1'b0, sLoad = 1'b0, subMode = 1'b0;
  logic [W-1:0] aLoadData = '0, sLoadData = '0, opA = '0, opB = '0;
  logic [W-1:0] sumComb, sumQ, sumCombO, sumQO;
  logic carryComb, carryQ, carryCombO, carryQO;
  int nChecks = 0, nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  csAddSub #(.WIDTH(W), .CHAIN_START(0)) u_dut (
    .clk(clk), .aClr(aClr), .aLoad(aLoad), .aLoadData(aLoadData), .clkEn(clkEn),
    .sClr(sClr), .sLoad(sLoad), .sLoadData(sLoadData), .subMode(subMode),
    .opA(opA), .opB(opB), .sumComb(sumComb), .carryComb(carryComb),
    .sumQ(sumQ), .carryQ(carryQ));

  csAddSub #(.WIDTH(W), .CHAIN_START(OFS)) u_dutOff (
    .clk(clk), .aClr(aClr), .aLoad(aLoad), .aLoadData(aLoadData), .clkEn(clkEn),
    .sClr(sClr), .sLoad(sLoad), .sLoadData(sLoadData), .subMode(subMode),
    .opA(opA), .opB(opB), .sumComb(sumCombO), .carryComb(carryCombO),
    .sumQ(sumQO), .carryQ(carryQO));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W:0] refFull(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
    logic [W-1:0] bb = s ? ~b : b;
    return {1'b0, a} + {1'b0, bb} + {{W{1'b0}}, s};
  endfunction

  function automatic logic [W:0] refOff(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
    logic [W-OFS-1:0] bh = s ? ~b[W-1:OFS] : b[W-1:OFS];
    logic [W-OFS:0] hi = {1'b0, a[W-1:OFS]} + {1'b0, bh} + {{(W-OFS){1'b0}}, s};
    return {hi, a[OFS-1:0]};
  endfunction

  // One enabled operation; checks combinational carry then registered result
  task automatic runOp(input string req, input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
    logic [W:0] e = refFull(a, b, s);
    @(negedge clk);
    opA = a; opB = b; subMode = s; clkEn = 1'b1; sClr = 1'b0; sLoad = 1'b0;
    #1;
    chk({req, " R4 comb carry"}, 32'(carryComb), 32'(e[W]));
    @(negedge clk);
    chk({req, " sum"}, 32'(sumQ), 32'(e[W-1:0]));
    chk({req, " carry"}, 32'(carryQ), 32'(e[W]));
  endtask

  task automatic testAdd();
    runOp("R1 add", 20'h12345, 20'h54321, 1'b0);
    runOp("R1 add wrap", 20'hFFFFF, 20'hFFFFF, 1'b0);
    runOp("R1 zero", 20'h00000, 20'h00000, 1'b0);
  endtask

  task automatic testBoundary();
    runOp("R3 bit4to5", 20'h0001F, 20'h00001, 1'b0);
    runOp("R3 bit9to10", 20'h003FF, 20'h00001, 1'b0);
    runOp("R3 bit14to15", 20'h07FFF, 20'h00001, 1'b0);
    runOp("R3 full ripple", 20'hFFFFF, 20'h00001, 1'b0);
    runOp("R3 sub borrow ripple", 20'h00000, 20'h00001, 1'b1);
  endtask

  task automatic testSub();
    runOp("R2 sub ge", 20'h00005, 20'h00003, 1'b1);
    runOp("R2 sub lt", 20'h00003, 20'h00005, 1'b1);
    runOp("R2 sub equal", 20'hABCDE, 20'hABCDE, 1'b1);
    runOp("R2 sub max", 20'hFFFFF, 20'h00000, 1'b1);
  endtask

  task automatic testHold();
    logic [W:0] e = refFull(20'h11111, 20'h22222, 1'b0);
    runOp("R5 prep", 20'h11111, 20'h22222, 1'b0);
    @(negedge clk);
    clkEn = 1'b0; opA = 20'h0F0F0; opB = 20'h0F0F0;
    @(negedge clk); @(negedge clk);
    chk("R5 hold sum", 32'(sumQ), 32'(e[W-1:0]));
    chk("R5 hold carry", 32'(carryQ), 32'(e[W]));
  endtask

  task automatic testSync();
    runOp("R9 prep", 20'hFFFFF, 20'h00001, 1'b0);
    // sLoad alone
    @(negedge clk);
    clkEn = 1'b1; sLoad = 1'b1; sLoadData = 20'h5A5A5;
    @(negedge clk);
    chk("R9 sload sum", 32'(sumQ), 32'h5A5A5);
    chk("R9 sload carry", 32'(carryQ), 32'h0);
    // both together with live operands: clear wins
    opA = 20'h12345; opB = 20'h11111; sClr = 1'b1; sLoad = 1'b1;
    @(negedge clk);
    chk("R8 sclr over sload", 32'(sumQ), 32'h0);
    // both while disabled: ignored
    runOp("R10 prep", 20'hFFFFF, 20'h00001, 1'b0);
    @(negedge clk);
    clkEn = 1'b0; sClr = 1'b1; sLoad = 1'b1; sLoadData = 20'h33333;
    @(negedge clk);
    chk("R10 ignored sum", 32'(sumQ), 32'h0);
    chk("R10 ignored carry", 32'(carryQ), 32'h1);
    sClr = 1'b0;
    @(negedge clk);
    chk("R10 ignored sload", 32'(sumQ), 32'h0);
    sLoad = 1'b0;
  endtask

  task automatic testAsync();
    runOp("R7 prep", 20'hFFFFF, 20'h00001, 1'b0);
    @(posedge clk); #1;
    aLoadData = 20'hC3C3C; aLoad = 1'b1;
    #0.5;
    chk("R7 aload sum", 32'(sumQ), 32'hC3C3C);
    chk("R7 aload carry", 32'(carryQ), 32'h0);
    aClr = 1'b1;
    #0.5;
    chk("R6 aclr over aload", 32'(sumQ), 32'h0);
    aLoad = 1'b0; aClr = 1'b0;
    runOp("R6 recover", 20'h00010, 20'h00020, 1'b0);
    @(posedge clk); #1;
    aClr = 1'b1;
    #0.5;
    chk("R6 aclr immediate", 32'(sumQ), 32'h0);
    aClr = 1'b0;
  endtask

  task automatic runOff(input string req, input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
    logic [W:0] e = refOff(a, b, s);
    @(negedge clk);
    opA = a; opB = b; subMode = s; clkEn = 1'b1;
    #1;
    chk({req, " comb carry"}, 32'(carryCombO), 32'(e[W]));
    @(negedge clk);
    chk({req, " sum"}, 32'(sumQO), 32'(e[W-1:0]));
    chk({req, " carry"}, 32'(carryQO), 32'(e[W]));
  endtask

  task automatic testOffset();
    runOff("R11 add", 20'h00007, 20'h00007, 1'b0);
    runOff("R11 add wrap", 20'hFFFFF, 20'h00008, 1'b0);
    runOff("R11 sub", 20'h00015, 20'h0002F, 1'b1);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    #1;
    chk("R6 reset sum", 32'(sumQ), 32'h0);
    chk("R6 reset carry", 32'(carryQ), 32'h0);
    @(negedge clk); @(negedge clk);
    aClr = 1'b0;
    testAdd();
    testBoundary();
    testSub();
    testHold();
    testSync();
    testAsync();
    testOffset();
    finishRun();
  end

  initial begin
    #(4 * 100000);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end
endmodule